// File: doc/BRIEF.md
# Per-Bank Open-Row Tracker

This block sits between a request splitter and the transfer stage of a synchronous DRAM controller. Each incoming sub-request carries a bank, a row, a column, a direction and an optional "close after use" hint. The tracker keeps, for every bank, whether a row is open and which one it is. From that it decides what the head request needs next and emits one command per cycle to the transfer stage.

A page hit goes straight out as a column command. A miss on an open bank first closes the bank, then opens the wanted row, then issues the column command. A request to a bank with no open row skips the close step. Requests are held in a small in-order queue whose usable depth is programmable.

A command leaves only in a cycle where the transfer stage signals readiness for that command kind. The bank's programmed row timing must also have elapsed: open-to-close, close-to-open and open-to-column. A refresh indication from the transfer stage marks every row closed.

Top module: `row_tracker`

## Requirements
- R1: A request whose bank has the same row open produces only a column command: read (`cmd_op`=10) or write (`cmd_op`=11), with `cmd_addr` equal to the zero-extended column. It produces no precharge and no activate.
- R2: A request whose bank has a different row open produces, in order, precharge (`cmd_op`=00), activate (`cmd_op`=01, `cmd_addr`=row), then the column command.
- R3: A request to a bank with no open row produces activate then the column command, with no precharge.
- R4: A read or write to a bank is issued no sooner than `cfg_trcd`+1 cycles after that bank's activate.
- R5: An activate to a bank is issued no sooner than `cfg_trp`+1 cycles after that bank's precharge.
- R6: A precharge to a bank is issued no sooner than `cfg_tras`+1 cycles after that bank's activate.
- R7: `cmd_valid` is high only when the ready input for that command is high. Precharge uses `pre_ok[cmd_bank]`; activate, read and write use `act_ok`, `rd_ok` and `wr_ok`. No command is issued while `refresh` is high.
- R8: After the column command of a request with `req_close`=1, the next command is a precharge of that bank. The bank is then closed, so a following request to the same row receives an activate.
- R9: A cycle with `refresh` high marks every bank closed, so the next request to any bank starts with an activate.
- R10: `req_ready` is low exactly when the queue holds `cfg_depth`+1 requests, and is otherwise high.
- R11: Requests are served in arrival order, and each `cmd_valid` cycle issues exactly one command.
- R12: After reset no row is open, `req_ready` is high and `cmd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_tras | input | 4 | Activate-to-precharge delay |
| cfg_trp | input | 4 | Precharge-to-activate delay |
| cfg_trcd | input | 4 | Activate-to-column delay |
| cfg_depth | input | 2 | Queue limit minus one |
| req_valid | input | 1 | Sub-request present |
| req_ready | output | 1 | Sub-request accepted when high with req_valid |
| req_bank | input | BA_W | Bank of request |
| req_row | input | ROW_W | Row of request |
| req_col | input | COL_W | Column of request |
| req_write | input | 1 | 1 write, 0 read |
| req_close | input | 1 | Close bank after this request |
| refresh | input | 1 | Refresh in progress, all rows closed |
| pre_ok | input | NB | Per-bank precharge readiness |
| act_ok | input | 1 | Activate readiness |
| rd_ok | input | 1 | Read readiness |
| wr_ok | input | 1 | Write readiness |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_op | output | 2 | 00 precharge, 01 activate, 10 read, 11 write |
| cmd_bank | output | BA_W | Command bank |
| cmd_addr | output | ADDR_W | Row for activate, column for read/write |

## Verification
The timing properties take the three delay inputs and the queue limit as static while traffic flows, and the bench changes `cfg_depth` only with the queue empty. They also assume the transfer stage holds `refresh` high for a single idle stretch rather than in the middle of a bank's open/close sequence. The bench raises refresh only after all expected commands have drained. The readiness inputs are otherwise free, and the bench holds some of them low for stretches to show that commands wait.

// File: rtl/rt_pkg.sv
// Shared definitions for the open-row tracker.
package rt_pkg;
    // Command code to the transfer stage; bit 1 set means a column command.
    typedef enum logic [1:0] {
        OP_PRE = 2'b00,
        OP_ACT = 2'b01,
        OP_RD  = 2'b10,
        OP_WR  = 2'b11
    } rt_op_e;
endpackage

// File: rtl/rt_req_fifo.sv
// In-order request queue.
// Assumes DEPTH is a power of two; push is never given while full.
module rt_req_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;

    // Storage write.
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign dout = mem[rp];
endmodule

// File: rtl/rt_bank_slot.sv
// State of one bank: open flag, open row and three row-timing counters.
// Each counter loads its delay on the triggering command and counts to zero.
// A counter at zero allows the command it gates.
// Assumes at most one of act_fire / pre_fire per cycle.
module rt_bank_slot #(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_fire,
    input  logic             pre_fire,
    input  logic             inval_all,
    input  logic [ROW_W-1:0] act_row,
    input  logic [3:0]       cfg_tras,
    input  logic [3:0]       cfg_trp,
    input  logic [3:0]       cfg_trcd,
    output logic             is_open,
    output logic [ROW_W-1:0] open_row,
    output logic             tras_done,
    output logic             trp_done,
    output logic             trcd_done
);
    logic [3:0] tras_cnt, trp_cnt, trcd_cnt;

    // Open flag and row register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_open  <= 1'b0;
            open_row <= '0;
        end else if (inval_all) begin
            is_open <= 1'b0;
        end else if (act_fire) begin
            is_open  <= 1'b1;
            open_row <= act_row;
        end else if (pre_fire) begin
            is_open <= 1'b0;
        end
    end

    // Row-timing countdowns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tras_cnt <= '0;
            trp_cnt  <= '0;
            trcd_cnt <= '0;
        end else begin
            if (act_fire)            tras_cnt <= cfg_tras;
            else if (tras_cnt != 0)  tras_cnt <= tras_cnt - 1'b1;
            if (act_fire)            trcd_cnt <= cfg_trcd;
            else if (trcd_cnt != 0)  trcd_cnt <= trcd_cnt - 1'b1;
            if (pre_fire)            trp_cnt  <= cfg_trp;
            else if (trp_cnt != 0)   trp_cnt  <= trp_cnt - 1'b1;
        end
    end

    assign tras_done = (tras_cnt == 0);
    assign trp_done  = (trp_cnt == 0);
    assign trcd_done = (trcd_cnt == 0);
endmodule

// File: rtl/rt_sequencer.sv
// Picks the next command for the queue head from bank state.
// The order is: pending close first, then hit, miss-on-open and closed-bank handling.
// Assumes bank state is valid for the head bank index.
module rt_sequencer #(
    parameter int NB     = 4,
    parameter int ROW_W  = 12,
    parameter int COL_W  = 10,
    parameter int BA_W   = 2,
    parameter int ADDR_W = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      head_valid,
    input  logic [BA_W-1:0]           hd_bank,
    input  logic [ROW_W-1:0]          hd_row,
    input  logic [COL_W-1:0]          hd_col,
    input  logic                      hd_write,
    input  logic                      hd_close,
    input  logic                      refresh,
    input  logic [NB-1:0]             pre_ok,
    input  logic                      act_ok,
    input  logic                      rd_ok,
    input  logic                      wr_ok,
    input  logic [NB-1:0]             bk_open,
    input  logic [NB-1:0][ROW_W-1:0]  bk_row,
    input  logic [NB-1:0]             bk_tras_done,
    input  logic [NB-1:0]             bk_trp_done,
    input  logic [NB-1:0]             bk_trcd_done,
    output logic                      cmd_valid,
    output rt_pkg::rt_op_e            cmd_op,
    output logic [BA_W-1:0]           cmd_bank,
    output logic [ADDR_W-1:0]         cmd_addr,
    output logic                      pop,
    output logic [NB-1:0]             act_fire,
    output logic [NB-1:0]             pre_fire
);
    import rt_pkg::*;

    logic            close_pend;
    logic [BA_W-1:0] close_bank;
    logic            set_close;

    // Command choice for this cycle.
    always_comb begin
        cmd_valid = 1'b0;
        cmd_op    = OP_PRE;
        cmd_bank  = hd_bank;
        cmd_addr  = '0;
        pop       = 1'b0;
        set_close = 1'b0;
        if (!refresh) begin
            if (close_pend) begin
                cmd_bank  = close_bank;
                cmd_valid = bk_tras_done[close_bank] && pre_ok[close_bank];
            end else if (head_valid) begin
                if (bk_open[hd_bank] && bk_row[hd_bank] == hd_row) begin
                    cmd_op    = hd_write ? OP_WR : OP_RD;
                    cmd_addr  = ADDR_W'(hd_col);
                    cmd_valid = bk_trcd_done[hd_bank] && (hd_write ? wr_ok : rd_ok);
                    pop       = cmd_valid;
                    set_close = cmd_valid && hd_close;
                end else if (bk_open[hd_bank]) begin
                    cmd_valid = bk_tras_done[hd_bank] && pre_ok[hd_bank];
                end else begin
                    cmd_op    = OP_ACT;
                    cmd_addr  = ADDR_W'(hd_row);
                    cmd_valid = bk_trp_done[hd_bank] && act_ok;
                end
            end
        end
    end

    // One-hot fire strobes to the bank slots.
    always_comb begin
        act_fire = '0;
        pre_fire = '0;
        act_fire[cmd_bank] = cmd_valid && (cmd_op == OP_ACT);
        pre_fire[cmd_bank] = cmd_valid && (cmd_op == OP_PRE);
    end

    // Pending close after a request carrying the close hint.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            close_pend <= 1'b0;
            close_bank <= '0;
        end else if (refresh) begin
            close_pend <= 1'b0;
        end else if (set_close) begin
            close_pend <= 1'b1;
            close_bank <= hd_bank;
        end else if (close_pend && cmd_valid) begin
            close_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/row_tracker.sv
// Per-bank open-row tracker: queues sub-requests, resolves hit/miss against
// each bank's open row and issues precharge/activate/column commands.
// Assumes cfg inputs are static during traffic and DEPTH is a power of two.
module row_tracker #(
    parameter int NB     = 4,
    parameter int ROW_W  = 12,
    parameter int COL_W  = 10,
    parameter int DEPTH  = 4,
    localparam int BA_W   = (NB > 1) ? $clog2(NB) : 1,
    localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        cfg_tras,
    input  logic [3:0]        cfg_trp,
    input  logic [3:0]        cfg_trcd,
    input  logic [1:0]        cfg_depth,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BA_W-1:0]   req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_write,
    input  logic              req_close,
    input  logic              refresh,
    input  logic [NB-1:0]     pre_ok,
    input  logic              act_ok,
    input  logic              rd_ok,
    input  logic              wr_ok,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [BA_W-1:0]   cmd_bank,
    output logic [ADDR_W-1:0] cmd_addr
);
    localparam int RW = 2 + BA_W + ROW_W + COL_W;
    localparam int CW = $clog2(DEPTH + 1);

    logic [RW-1:0]            q_din, q_dout;
    logic [CW-1:0]            q_count, limit;
    logic                     push, pop;
    logic                     hd_write, hd_close;
    logic [BA_W-1:0]          hd_bank;
    logic [ROW_W-1:0]         hd_row;
    logic [COL_W-1:0]         hd_col;
    logic [NB-1:0]            act_fire, pre_fire;
    logic [NB-1:0]            bk_open, bk_tras_done, bk_trp_done, bk_trcd_done;
    logic [NB-1:0][ROW_W-1:0] bk_row;
    rt_pkg::rt_op_e           op_e;

    // Queue limit from configuration, clamped to physical depth.
    always_comb begin
        limit = CW'(cfg_depth) + 1'b1;
        if (limit > CW'(DEPTH)) limit = CW'(DEPTH);
    end

    assign req_ready = (q_count < limit);
    assign push      = req_valid && req_ready;
    assign q_din     = {req_write, req_close, req_bank, req_row, req_col};
    assign {hd_write, hd_close, hd_bank, hd_row, hd_col} = q_dout;

    rt_req_fifo #(.W(RW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (q_din),
        .pop   (pop),
        .dout  (q_dout),
        .count (q_count)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        rt_bank_slot #(.ROW_W(ROW_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .act_fire  (act_fire[b]),
            .pre_fire  (pre_fire[b]),
            .inval_all (refresh),
            .act_row   (hd_row),
            .cfg_tras  (cfg_tras),
            .cfg_trp   (cfg_trp),
            .cfg_trcd  (cfg_trcd),
            .is_open   (bk_open[b]),
            .open_row  (bk_row[b]),
            .tras_done (bk_tras_done[b]),
            .trp_done  (bk_trp_done[b]),
            .trcd_done (bk_trcd_done[b])
        );
    end

    rt_sequencer #(
        .NB(NB), .ROW_W(ROW_W), .COL_W(COL_W), .BA_W(BA_W), .ADDR_W(ADDR_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .head_valid   (q_count != 0),
        .hd_bank      (hd_bank),
        .hd_row       (hd_row),
        .hd_col       (hd_col),
        .hd_write     (hd_write),
        .hd_close     (hd_close),
        .refresh      (refresh),
        .pre_ok       (pre_ok),
        .act_ok       (act_ok),
        .rd_ok        (rd_ok),
        .wr_ok        (wr_ok),
        .bk_open      (bk_open),
        .bk_row       (bk_row),
        .bk_tras_done (bk_tras_done),
        .bk_trp_done  (bk_trp_done),
        .bk_trcd_done (bk_trcd_done),
        .cmd_valid    (cmd_valid),
        .cmd_op       (op_e),
        .cmd_bank     (cmd_bank),
        .cmd_addr     (cmd_addr),
        .pop          (pop),
        .act_fire     (act_fire),
        .pre_fire     (pre_fire)
    );

    assign cmd_op = op_e;
endmodule

// File: rtl/rt_checker.sv
// Port-level properties of the open-row tracker, attached by bind.
// Keeps its own shadow of bank state and cycle counts since commands.
module rt_checker #(
    parameter int NB     = 4,
    parameter int BA_W   = 2,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        cfg_tras,
    input logic [3:0]        cfg_trp,
    input logic [3:0]        cfg_trcd,
    input logic [1:0]        cfg_depth,
    input logic              req_valid,
    input logic              req_ready,
    input logic              refresh,
    input logic [NB-1:0]     pre_ok,
    input logic              act_ok,
    input logic              rd_ok,
    input logic              wr_ok,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic [BA_W-1:0]   cmd_bank,
    input logic [ADDR_W-1:0] cmd_addr
);
    logic          sel_ok;
    logic [NB-1:0] sh_open;
    logic [4:0]    since_act [NB];
    logic [4:0]    since_pre [NB];
    logic [3:0]    held;
    logic          addr_seen;

    // Readiness matching the issued command kind.
    always_comb begin
        case (cmd_op)
            2'b00:   sel_ok = pre_ok[cmd_bank];
            2'b01:   sel_ok = act_ok;
            2'b10:   sel_ok = rd_ok;
            default: sel_ok = wr_ok;
        endcase
    end

    assign addr_seen = ^cmd_addr;

    // Shadow open flags from the command stream.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_open <= '0;
        else if (refresh) sh_open <= '0;
        else if (cmd_valid && cmd_op == 2'b01) sh_open[cmd_bank] <= 1'b1;
        else if (cmd_valid && cmd_op == 2'b00) sh_open[cmd_bank] <= 1'b0;
    end

    // Shadow queue occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) held <= '0;
        else held <= held + 4'(req_valid && req_ready) - 4'(cmd_valid && cmd_op[1]);
    end

    for (genvar b = 0; b < NB; b++) begin : g_tm
        // Saturating cycle counts since this bank's activate and precharge.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                since_act[b] <= 5'd31;
                since_pre[b] <= 5'd31;
            end else begin
                if (cmd_valid && cmd_bank == BA_W'(b) && cmd_op == 2'b01) since_act[b] <= '0;
                else if (since_act[b] != 5'd31) since_act[b] <= since_act[b] + 1'b1;
                if (cmd_valid && cmd_bank == BA_W'(b) && cmd_op == 2'b00) since_pre[b] <= '0;
                else if (since_pre[b] != 5'd31) since_pre[b] <= since_pre[b] + 1'b1;
            end
        end

        // R4
        trcd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && cmd_op[1] && cmd_bank == BA_W'(b)) |-> since_act[b] >= {1'b0, cfg_trcd});
        // R5
        trp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && cmd_op == 2'b01 && cmd_bank == BA_W'(b)) |-> since_pre[b] >= {1'b0, cfg_trp});
        // R6
        tras_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && cmd_op == 2'b00 && cmd_bank == BA_W'(b)) |-> since_act[b] >= {1'b0, cfg_tras});
    end

    // R7
    ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> sel_ok);
    // R7
    refresh_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |-> !cmd_valid);
    // R1
    col_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op[1]) |-> sh_open[cmd_bank]);
    // R3
    pre_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'b00) |-> sh_open[cmd_bank]);
    // R2
    act_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'b01) |-> !sh_open[cmd_bank]);
    // R10
    held_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held <= {2'b00, cfg_depth} + 4'd1);
    // R11
    addr_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !$isunknown(addr_seen));
endmodule

bind row_tracker rt_checker #(.NB(NB), .BA_W(BA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_tras  (cfg_tras),
    .cfg_trp   (cfg_trp),
    .cfg_trcd  (cfg_trcd),
    .cfg_depth (cfg_depth),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .refresh   (refresh),
    .pre_ok    (pre_ok),
    .act_ok    (act_ok),
    .rd_ok     (rd_ok),
    .wr_ok     (wr_ok),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_bank  (cmd_bank),
    .cmd_addr  (cmd_addr)
);

// File: tb/row_tracker_tb.sv
// Scoreboard bench: the driver predicts commands into a queue; the monitor
// compares every issued command against it and checks spacing.
module row_tracker_tb;
    localparam int NB = 4, ROW_W = 12, COL_W = 10, BA_W = 2, ADDR_W = 12;
    localparam int TRAS = 5, TRP = 2, TRCD = 3;

    typedef struct {
        logic [1:0] op;
        int         bank;
        int         addr;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n;
    logic [3:0]        cfg_tras, cfg_trp, cfg_trcd;
    logic [1:0]        cfg_depth;
    logic              req_valid, req_ready, req_write, req_close, refresh;
    logic [BA_W-1:0]   req_bank;
    logic [ROW_W-1:0]  req_row;
    logic [COL_W-1:0]  req_col;
    logic [NB-1:0]     pre_ok;
    logic              act_ok, rd_ok, wr_ok, cmd_valid;
    logic [1:0]        cmd_op;
    logic [BA_W-1:0]   cmd_bank;
    logic [ADDR_W-1:0] cmd_addr;

    row_tracker u_dut (.*);

    int   checks = 0, fails = 0, cyc = 0;
    exp_t exp_q[$];
    bit   open_m [NB];
    int   row_m [NB];
    int   act_cyc [NB];
    int   pre_cyc [NB];

    always @(posedge clk) cyc++;

    task automatic chk(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic expect_cmd(logic [1:0] op, int b, int a, string tag);
        exp_t e;
        e.op = op; e.bank = b; e.addr = a; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare each issued command with the prediction.
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            int  b;
            bit  okv;
            b = int'(cmd_bank);
            case (cmd_op)
                2'b00:   okv = pre_ok[b];
                2'b01:   okv = act_ok;
                2'b10:   okv = rd_ok;
                default: okv = wr_ok;
            endcase
            chk(okv && !refresh, "R7", "command issued without readiness", 0, 1);
            if (exp_q.size() == 0) begin
                chk(0, "R11", "unexpected command op", int'(cmd_op), -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(cmd_op == e.op, e.tag, "op", int'(cmd_op), int'(e.op));
                chk(b == e.bank, e.tag, "bank", b, e.bank);
                if (cmd_op != 2'b00)
                    chk(int'(cmd_addr) == e.addr, e.tag, "addr", int'(cmd_addr), e.addr);
            end
            if (cmd_op[1]) chk(cyc - act_cyc[b] >= TRCD + 1, "R4", "act-to-col gap", cyc - act_cyc[b], TRCD + 1);
            if (cmd_op == 2'b01) begin
                chk(cyc - pre_cyc[b] >= TRP + 1, "R5", "pre-to-act gap", cyc - pre_cyc[b], TRP + 1);
                act_cyc[b] = cyc;
            end
            if (cmd_op == 2'b00) begin
                chk(cyc - act_cyc[b] >= TRAS + 1, "R6", "act-to-pre gap", cyc - act_cyc[b], TRAS + 1);
                pre_cyc[b] = cyc;
            end
        end
    end

    // Driver: predict commands from the open-row model, then hand the request in.
    task automatic send_req(int b, int row, int col, bit wr, bit cl);
        string ctag;
        if (open_m[b] && row_m[b] == row) begin
            ctag = "R1";
        end else if (open_m[b]) begin
            expect_cmd(2'b00, b, 0, "R2");
            expect_cmd(2'b01, b, row, "R2");
            ctag = "R2";
        end else begin
            expect_cmd(2'b01, b, row, "R3");
            ctag = "R3";
        end
        expect_cmd(wr ? 2'b11 : 2'b10, b, col, ctag);
        open_m[b] = 1'b1;
        row_m[b]  = row;
        if (cl) begin
            expect_cmd(2'b00, b, 0, "R8");
            open_m[b] = 1'b0;
        end
        @(posedge clk); #1;
        req_valid = 1'b1; req_bank = BA_W'(b); req_row = ROW_W'(row);
        req_col = COL_W'(col); req_write = wr; req_close = cl;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R11", "pending expected commands", exp_q.size(), 0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R11 watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NB; i++) begin
            open_m[i] = 0; row_m[i] = 0; act_cyc[i] = -1000; pre_cyc[i] = -1000;
        end
        rst_n = 0; cfg_tras = 4'(TRAS); cfg_trp = 4'(TRP); cfg_trcd = 4'(TRCD);
        cfg_depth = 2'd3; req_valid = 0; req_bank = '0; req_row = '0; req_col = '0;
        req_write = 0; req_close = 0; refresh = 0; pre_ok = '1;
        act_ok = 1; rd_ok = 1; wr_ok = 1;
        repeat (3) @(posedge clk); #1;
        rst_n = 1;
        @(negedge clk);
        // R12: reset state at the ports
        chk(req_ready == 1'b1, "R12", "req_ready after reset", int'(req_ready), 1);
        chk(cmd_valid == 1'b0, "R12", "cmd_valid after reset", int'(cmd_valid), 0);

        send_req(0, 5, 7, 0, 0);   // R3 closed bank
        send_req(0, 5, 8, 1, 0);   // R1 hit
        drain();

        // R7: precharge waits for its bank readiness
        @(posedge clk); #1; pre_ok = 4'b1110;
        send_req(0, 9, 1, 0, 0);   // R2 miss
        repeat (12) @(negedge clk);
        chk(exp_q.size() == 3, "R7", "commands left while precharge blocked", exp_q.size(), 3);
        @(posedge clk); #1; pre_ok = '1;
        drain();

        send_req(1, 3, 2, 1, 1);   // R8 close hint
        send_req(1, 3, 4, 0, 0);   // R8 same row needs activate again
        send_req(2, 6, 5, 1, 0);
        drain();

        // R9: refresh closes every bank
        @(posedge clk); #1; refresh = 1;
        @(negedge clk);
        chk(cmd_valid == 1'b0, "R9", "command during refresh", int'(cmd_valid), 0);
        @(posedge clk); #1; refresh = 0;
        for (int i = 0; i < NB; i++) open_m[i] = 0;
        send_req(0, 9, 3, 0, 0);
        send_req(2, 6, 6, 1, 0);
        drain();

        // R10: queue limit of two with reads held back
        @(posedge clk); #1; cfg_depth = 2'd1; rd_ok = 0;
        send_req(0, 9, 10, 0, 0);
        @(negedge clk);
        chk(req_ready == 1'b1, "R10", "ready with one held", int'(req_ready), 1);
        send_req(0, 9, 11, 0, 0);
        @(negedge clk);
        chk(req_ready == 1'b0, "R10", "ready at limit", int'(req_ready), 0);
        chk(exp_q.size() == 2, "R7", "reads issued while rd_ok low", exp_q.size(), 2);
        @(posedge clk); #1; rd_ok = 1;
        drain();
        @(negedge clk);
        chk(req_ready == 1'b1, "R10", "ready after drain", int'(req_ready), 1);
        finish_run();
    end
endmodule